// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers a vector of single-cycle interrupt events from the rest of a chip and turns them into one interrupt pin. Each event source has an enable bit in a mask register. When an event pulse arrives while its enable bit is set, the matching bit of a sticky monitor register is latched. The mask is applied before the latch, so changing the mask later never drops a bit that has already been latched. Software clears latched bits by writing ones to them.

The interrupt is raised while any monitor bit is set. A 2-bit drive-mode field sets how the pin behaves. Two modes are open-drain styles: the pin floats when idle and is driven low, or driven high, when raised. The other two modes are push-pull of either polarity. The pin is presented as a data value plus an output enable, so the pad ring can build any of the four styles.

A small word-addressed register port writes the mask and the mode and reads back every register. With the default widths of 64 sources and 32-bit words, word 0 holds mask sources 0..31 and word 1 holds mask sources 32..63. Words 2 and 3 are the monitor for the same ranges. Word 4 holds the mode in bits [1:0].

Top module: `irq_sticky_ctrl`

## Requirements
- R1: On a clock edge where evt_i[i] is 1 and mask bit i is 1, monitor bit i reads 1 from the next cycle on.
- R2: An event whose mask bit is 0 sets no monitor bit and does not raise the interrupt.
- R3: Writing a mask bit to 0 leaves the corresponding monitor bit set. A set monitor bit stays set until software clears it.
- R4: Writing a monitor word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an event for a masked-in source and a write-1 clear of the same bit happen on the same edge, the bit ends up set.
- R6: irq_o is 1 exactly when at least one monitor bit is 1. Several monitor bits can be set at once, and each one reads back at its own position.
- R7: In mode 00 (the reset default), pin_oe_o is 0 while the interrupt is idle. While the interrupt is raised, pin_oe_o is 1 and pin_data_o is 0.
- R8: In mode 01, pin_oe_o is 0 while the interrupt is idle. While the interrupt is raised, pin_oe_o is 1 and pin_data_o is 1.
- R9: In modes 10 and 11, pin_oe_o is always 1. In mode 10, pin_data_o equals the interrupt. In mode 11, pin_data_o is its inverse.
- R10: After reset, all mask bits are 0, all monitor bits are 0 and the mode is 00.
- R11: The register map is as follows. Word w < 2 is mask sources 32w..32w+31, with bit b mapping to source 32w+b. Words 2 and 3 are the monitor with the same bit mapping. Word 4 bits [1:0] are the mode, and its other bits read 0. Words 5..7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 64 | Interrupt event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Logical interrupt, active high |
| pin_data_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The assertions assume three things about the inputs. Events are sampled as plain levels on each clock edge. The register port writes at most one word per cycle. The address settles before the edge on which the write strobe is sampled. The stimulus respects these assumptions by changing every input on the falling clock edge and holding each event or write for exactly one cycle. Simultaneous events and clears are applied on purpose, so that the event-wins rule and the hold rule are exercised on the same edge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    DRV_OD_LOW  = 2'b00,
    DRV_OD_HIGH = 2'b01,
    DRV_PP_HIGH = 2'b10,
    DRV_PP_LOW  = 2'b11
  } drv_mode_e;

  typedef struct packed {
    logic data;
    logic oe;
  } pin_drive_t;

  // Pin value and enable for a drive mode and a logical interrupt level.
  function automatic pin_drive_t drive_for(logic [1:0] mode, logic active);
    pin_drive_t d;
    case (drv_mode_e'(mode))
      DRV_OD_LOW:  begin d.oe = active; d.data = 1'b0;    end
      DRV_OD_HIGH: begin d.oe = active; d.data = 1'b1;    end
      DRV_PP_HIGH: begin d.oe = 1'b1;   d.data = active;  end
      default:     begin d.oe = 1'b1;   d.data = ~active; end
    endcase
    return d;
  endfunction

  // Next value of a sticky bit: a masked event wins over a clear.
  function automatic logic sticky_next(logic cur, logic evt, logic en, logic clr);
    return (cur & ~clr) | (evt & en);
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] mon,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] clr,
  output logic [1:0]         mode,
  output logic [REG_W-1:0]   rdata
);
  localparam int WORDS     = NUM_SRC / REG_W;
  localparam int MON_BASE  = WORDS;
  localparam int MODE_ADDR = 2 * WORDS;

  logic [NUM_SRC-1:0] mask_q;
  logic [1:0]         mode_q;
  logic               mode_wr;
  logic               unmapped_wr;

  assign mode_wr     = wr_en && (addr == ADDR_W'(MODE_ADDR));
  assign unmapped_wr = wr_en && (addr > ADDR_W'(MODE_ADDR));

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic mask_wr;
    logic mon_wr;
    assign mask_wr = wr_en && (addr == ADDR_W'(w));
    assign mon_wr  = wr_en && (addr == ADDR_W'(MON_BASE + w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q[w*REG_W +: REG_W] <= '0;
      else if (mask_wr) mask_q[w*REG_W +: REG_W] <= wdata;
    end

    assign clr[w*REG_W +: REG_W] = mon_wr ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= DRV_OD_LOW;
    else if (mode_wr) mode_q <= wdata[1:0];
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (addr == ADDR_W'(w))            rdata = mask_q[w*REG_W +: REG_W];
      if (addr == ADDR_W'(MON_BASE + w)) rdata = mon[w*REG_W +: REG_W];
    end
    if (addr == ADDR_W'(MODE_ADDR)) rdata = {{(REG_W-2){1'b0}}, mode_q};
  end

  assign mask = mask_q;
  assign mode = mode_q;

  // R11: writes to unmapped words touch no configuration state
  p_unmapped_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> ($stable(mask_q) && $stable(mode_q)));

  // R10: the mode changes only on a write to the mode word
  p_mode_only_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] mon
);
  logic [NUM_SRC-1:0] mon_q;
  logic [NUM_SRC-1:0] gated_evt;

  assign gated_evt = evt & mask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mon_q[i] <= 1'b0;
      else        mon_q[i] <= sticky_next(mon_q[i], evt[i], mask[i], clr[i]);
    end
  end

  assign mon = mon_q;

  // R1, R5: a masked event always leaves its bit set
  p_masked_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(gated_evt) & ~mon_q) == '0));

  // R2: a newly set bit needs a masked event on the previous edge
  p_no_unmasked_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mon_q & ~$past(mon_q) & ~$past(gated_evt)) == '0));

  // R3, R4: a set bit that was not cleared stays set
  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mon_q) & ~$past(clr) & ~mon_q) == '0));

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] mon,
  input  logic [1:0]         mode,
  output logic               active,
  output logic               pin_data,
  output logic               pin_oe
);
  pin_drive_t drv;

  assign active   = |mon;
  assign drv      = drive_for(mode, active);
  assign pin_data = drv.data;
  assign pin_oe   = drv.oe;

  always_comb begin
    // R7, R8: open-drain modes float while idle
    p_od_idle_float_r7: assert (!((mode[1] == 1'b0) && !active && pin_oe));
    // R8: mode 01 drives high while raised
    p_od_high_level_r8: assert (!((mode == 2'b01) && active && !(pin_oe && pin_data)));
    // R9: push-pull modes always drive
    p_pp_driven_r9: assert (!(mode[1] && !pin_oe));
  end

endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o,
  output logic               pin_data_o,
  output logic               pin_oe_o
);
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] mon;
  logic [1:0]         mode;
  logic               irq_active;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .mon(mon), .mask(mask), .clr(clr), .mode(mode), .rdata(rdata_o)
  );

  irq_sticky_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .mask(mask), .clr(clr), .mon(mon)
  );

  irq_pin_drv #(.NUM_SRC(NUM_SRC)) u_pin (
    .mon(mon), .mode(mode), .active(irq_active),
    .pin_data(pin_data_o), .pin_oe(pin_oe_o)
  );

  assign irq_o = irq_active;

  // R6: the interrupt cannot rise without a masked event on that edge
  p_irq_rise_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_active) |-> ($past(evt_i & mask) != '0));

endmodule

// File: tb/test_irq_sticky_ctrl.sv
module test_irq_sticky_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, pin_d, pin_oe;
  int checks = 0;
  int fails = 0;

  irq_sticky_ctrl i_irq_sticky_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pin_data_o(pin_d), .pin_oe_o(pin_oe)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(logic [63:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic check_pin(string req, logic [1:0] m, logic act);
    logic e_oe, e_d;
    case (m)
      2'b00: begin e_oe = act;  e_d = 1'b0; end
      2'b01: begin e_oe = act;  e_d = 1'b1; end
      2'b10: begin e_oe = 1'b1; e_d = act;  end
      default: begin e_oe = 1'b1; e_d = !act; end
    endcase
    #1;
    check({req, " oe"}, 64'(pin_oe), 64'(e_oe));
    if (e_oe) check({req, " data"}, 64'(pin_d), 64'(e_d));
    check({req, " irq"}, 64'(irq), 64'(act));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R10 reset reg", 64'(d), 64'h0);
    end
    check_pin("R10 R7 reset pin", 2'b00, 1'b0);
  endtask

  task automatic t_unmasked();
    logic [31:0] d;
    pulse('1);
    rd(3'd2, d); check("R2 mon0", 64'(d), 64'h0);
    rd(3'd3, d); check("R2 mon1", 64'(d), 64'h0);
    check_pin("R2 pin", 2'b00, 1'b0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    wr(3'd0, 32'h0000_00F0);
    wr(3'd1, 32'h8000_0001);
    rd(3'd0, d); check("R11 mask0 readback", 64'(d), 64'h0000_00F0);
    rd(3'd1, d); check("R11 mask1 readback", 64'(d), 64'h8000_0001);
    pulse(64'h8000_0001_0000_0018);
    rd(3'd2, d); check("R1 mon0", 64'(d), 64'h10);
    rd(3'd3, d); check("R1 R6 mon1", 64'(d), 64'h8000_0001);
    check_pin("R6 R7 raised", 2'b00, 1'b1);
  endtask

  task automatic t_mask_clear();
    logic [31:0] d;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    rd(3'd2, d); check("R3 mon0 kept", 64'(d), 64'h10);
    rd(3'd3, d); check("R3 mon1 kept", 64'(d), 64'h8000_0001);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(3'd3, 32'h0);
    rd(3'd3, d); check("R4 write0 keeps", 64'(d), 64'h8000_0001);
    wr(3'd3, 32'h1);
    rd(3'd3, d); check("R4 clear bit32", 64'(d), 64'h8000_0000);
    wr(3'd2, 32'h10);
    rd(3'd2, d); check("R4 clear bit4", 64'(d), 64'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(3'd0, 32'h1);
    pulse(64'h1);
    rd(3'd2, d); check("R5 pre set", 64'(d), 64'h1);
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 32'h1; evt = 64'h1;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rd(3'd2, d); check("R5 event wins", 64'(d), 64'h1);
    wr(3'd2, 32'h1);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R5 cleared0", 64'(d), 64'h0);
    rd(3'd3, d); check("R4 cleared1", 64'(d), 64'h0);
    check_pin("R6 R7 idle", 2'b00, 1'b0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    for (int m = 1; m < 4; m++) begin
      wr(3'd4, 32'hFFFF_FFFC | 32'(m));
      rd(3'd4, d); check("R11 mode readback", 64'(d), 64'(m));
      check_pin(m == 1 ? "R8 idle" : "R9 idle", 2'(m), 1'b0);
      pulse(64'h1);
      check_pin(m == 1 ? "R8 raised" : "R9 raised", 2'(m), 1'b1);
      wr(3'd2, 32'h1);
      check_pin(m == 1 ? "R8 cleared" : "R9 cleared", 2'(m), 1'b0);
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), d); check("R11 unmapped read", 64'(d), 64'h0);
    end
    rd(3'd0, d); check("R11 mask0 untouched", 64'(d), 64'h1);
    rd(3'd1, d); check("R11 mask1 untouched", 64'(d), 64'h0);
    rd(3'd4, d); check("R11 mode untouched", 64'(d), 64'h3);
    rd(3'd2, d); check("R11 mon untouched", 64'(d), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unmasked();
    t_masked();
    t_mask_clear();
    t_w1c();
    t_race();
    t_modes();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule